// File: doc/BRIEF.md
# DDR2 Command Spacing Guard

This block sits beside a DDR2 command scheduler and keeps it from issuing commands closer together than the memory allows. It holds one 32-bit timing register that software programs through a plain write/read port. Writes reach the register only while an external unlock input is high. The block reads the register's fields and turns them into "ok to issue" flags, one for each command class. Every spacing field uses a minus-one encoding: a field value of N keeps the matching flag low for N+1 memory-clock cycles after the triggering command.

The scheduler reports three kinds of event: a self-refresh exit, a read, and a request to flip the clock-enable pin. A self-refresh exit starts two separate countdowns, one for reads and one for every other command. A read starts the read-to-precharge countdown, and each new read restarts it. The block drives the clock-enable output itself. A flip request is honoured only while the clock-enable spacing has elapsed. The lead time between on-die-termination enable and write data is handed on unchanged to the write path.

Top module: `ddr_cmd_spacing_guard`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x01FFFFFF. This is lead 3 in bits 24:23, exit-to-non-read 0x7F in bits 22:16, exit-to-read 0xFF in bits 15:8, read-to-precharge 7 in bits 7:5 and clock-enable spacing 0x1F in bits 4:0. At the same time all four ok flags are high and `cke_out` is low.
- R2: Bits 31:25 of `cfg_rdata` always read zero, whatever is written to them.
- R3: A write (`cfg_wr` high at a clock edge) updates the register only if `cfg_unlock` is high. Otherwise the register keeps its value.
- R4: After `sr_exit` is sampled, `nonrd_ok` stays low for exactly (bits 22:16) + 1 cycles.
- R5: After `sr_exit` is sampled, `rd_ok` stays low for exactly (bits 15:8) + 1 cycles, counted apart from R4.
- R6: After `rd_issue` is sampled, `pre_ok` stays low for (bits 7:5) + 1 cycles. The count is measured from the most recent read. `pre_ok` is also low whenever `nonrd_ok` is low.
- R7: When `cke_flip_req` is high while `cke_flip_ok` is high, `cke_out` inverts at that edge. `cke_flip_ok` then stays low for (bits 4:0) + 1 cycles. While `cke_flip_ok` is low, requests are ignored and `cke_out` holds.
- R8: `odt_lead` always equals bits 24:23 of the register.
- R9: A countdown uses the field value captured at its triggering event. Rewriting the field during the countdown does not change the current count. The new value applies from the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_unlock | input | 1 | Write permission for the timing fields |
| cfg_rdata | output | 32 | Register read data |
| sr_exit | input | 1 | Self-refresh exit issued this cycle |
| rd_issue | input | 1 | Read command issued this cycle |
| cke_flip_req | input | 1 | Request to invert clock enable |
| cke_out | output | 1 | Clock-enable level to the memory |
| rd_ok | output | 1 | A read may be issued |
| nonrd_ok | output | 1 | A command other than a read may be issued |
| pre_ok | output | 1 | A precharge may be issued |
| cke_flip_ok | output | 1 | Clock enable may be inverted |
| odt_lead | output | 2 | ODT-enable to write-data lead, in cycles |

## Verification
The bench uses the default reset parameters. A first pass of register writes covers the reserved bits, the unlock gating and the read-back of the lead field. The bench then programs small spacings (5, 9, 2 and 3) so that every countdown runs out within a few dozen cycles. It measures the exact length of each blocked window and checks the separate read and non-read limits after one exit. It also checks the restart of the precharge count on back-to-back reads, the rejection of clock-enable requests while the spacing is running, and a field rewrite made in the middle of a countdown.

// File: rtl/dcg_pkg.sv
package dcg_pkg;
  localparam int REG_W   = 32;
  localparam int CKE_LSB = 0;
  localparam int CKE_W   = 5;
  localparam int RTP_LSB = 5;
  localparam int RTP_W   = 3;
  localparam int XRD_LSB = 8;
  localparam int XRD_W   = 8;
  localparam int XNR_LSB = 16;
  localparam int XNR_W   = 7;
  localparam int ODT_LSB = 23;
  localparam int ODT_W   = 2;
  localparam int USED_W  = ODT_LSB + ODT_W;

  typedef struct packed {
    logic [ODT_W-1:0] odt;
    logic [XNR_W-1:0] xnr;
    logic [XRD_W-1:0] xrd;
    logic [RTP_W-1:0] rtp;
    logic [CKE_W-1:0] cke;
  } dcg_fields_t;
endpackage

// File: rtl/dcg_timing_reg.sv
module dcg_timing_reg
  import dcg_pkg::*;
#(
  parameter logic [REG_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              unlock,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output dcg_fields_t       fields
);
  localparam logic [REG_W-1:0] KEEP_MASK = REG_W'((64'd1 << USED_W) - 64'd1);

  logic [REG_W-1:0] word_q, word_d;
  logic             wr_en;

  assign wr_en = wr & unlock;

  always_comb begin
    word_d = word_q;
    if (wr_en) word_d = wdata & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= RESET_WORD & KEEP_MASK;
    else if (wr_en) word_q <= word_d;
  end

  assign rdata  = word_q;
  assign fields = word_q[USED_W-1:0];
endmodule

// File: rtl/dcg_gap_timer.sv
module dcg_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] limit,
  output logic         ready
);
  localparam int CW = W + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = start | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = {1'b0, limit} + CW'(1);
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/dcg_cke_pacer.sv
module dcg_cke_pacer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] limit,
  output logic         cke,
  output logic         ok
);
  logic flip;
  logic cke_q, cke_d;

  assign flip = req & ok;

  always_comb begin
    cke_d = cke_q;
    if (flip) cke_d = ~cke_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cke_q <= 1'b0;
    else if (flip) cke_q <= cke_d;
  end

  dcg_gap_timer #(.W(W)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .start (flip),
    .limit (limit),
    .ready (ok)
  );

  assign cke = cke_q;
endmodule

// File: rtl/ddr_cmd_spacing_guard.sv
module ddr_cmd_spacing_guard
  import dcg_pkg::*;
#(
  parameter logic [ODT_W-1:0] RST_ODT = 2'h3,
  parameter logic [XNR_W-1:0] RST_XNR = 7'h7F,
  parameter logic [XRD_W-1:0] RST_XRD = 8'hFF,
  parameter logic [RTP_W-1:0] RST_RTP = 3'h7,
  parameter logic [CKE_W-1:0] RST_CKE = 5'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              cfg_unlock,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              sr_exit,
  input  logic              rd_issue,
  input  logic              cke_flip_req,
  output logic              cke_out,
  output logic              rd_ok,
  output logic              nonrd_ok,
  output logic              pre_ok,
  output logic              cke_flip_ok,
  output logic [ODT_W-1:0]  odt_lead
);
  localparam logic [REG_W-1:0] RESET_WORD =
    REG_W'({RST_ODT, RST_XNR, RST_XRD, RST_RTP, RST_CKE});

  dcg_fields_t f;
  logic        rtp_ready;

  dcg_timing_reg #(.RESET_WORD(RESET_WORD)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .unlock (cfg_unlock),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .fields (f)
  );

  dcg_gap_timer #(.W(XNR_W)) u_xnr (
    .clk (clk), .rst_n (rst_n), .start (sr_exit), .limit (f.xnr), .ready (nonrd_ok)
  );

  dcg_gap_timer #(.W(XRD_W)) u_xrd (
    .clk (clk), .rst_n (rst_n), .start (sr_exit), .limit (f.xrd), .ready (rd_ok)
  );

  dcg_gap_timer #(.W(RTP_W)) u_rtp (
    .clk (clk), .rst_n (rst_n), .start (rd_issue), .limit (f.rtp), .ready (rtp_ready)
  );

  dcg_cke_pacer #(.W(CKE_W)) u_cke (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (cke_flip_req),
    .limit (f.cke),
    .cke   (cke_out),
    .ok    (cke_flip_ok)
  );

  assign pre_ok   = rtp_ready & nonrd_ok;
  assign odt_lead = f.odt;
endmodule

// File: rtl/dcg_checker.sv
module dcg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [31:0] cfg_wdata,
  input logic        cfg_unlock,
  input logic [31:0] cfg_rdata,
  input logic        sr_exit,
  input logic        rd_issue,
  input logic        cke_flip_req,
  input logic        cke_out,
  input logic        rd_ok,
  input logic        nonrd_ok,
  input logic        pre_ok,
  input logic        cke_flip_ok,
  input logic [1:0]  odt_lead
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:25] == 7'd0); // R2

  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_unlock) |=> $stable(cfg_rdata)); // R3

  AST_NONRD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit |=> !nonrd_ok); // R4

  AST_RD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit |=> !rd_ok); // R5

  AST_PRE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> !pre_ok); // R6

  AST_PRE_NONRD: assert property (@(posedge clk) disable iff (!rst_n)
    pre_ok |-> nonrd_ok); // R6

  AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_flip_ok |=> $stable(cke_out)); // R7

  AST_CKE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_flip_req && cke_flip_ok) |=> (cke_out != $past(cke_out)) && !cke_flip_ok); // R7

  AST_ODT_EXPORT: assert property (@(posedge clk) disable iff (!rst_n)
    odt_lead == cfg_rdata[24:23]); // R8
endmodule

bind ddr_cmd_spacing_guard dcg_checker u_chk (.*);

// File: tb/ddr_cmd_spacing_guard_tb.sv
module ddr_cmd_spacing_guard_tb;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [31:0] cfg_wdata;
  logic        cfg_unlock;
  logic [31:0] cfg_rdata;
  logic        sr_exit;
  logic        rd_issue;
  logic        cke_flip_req;
  logic        cke_out;
  logic        rd_ok;
  logic        nonrd_ok;
  logic        pre_ok;
  logic        cke_flip_ok;
  logic [1:0]  odt_lead;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ddr_cmd_spacing_guard u_dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {unlock, write data, expected read-back}
  localparam int NV = 6;
  localparam logic [64:0] VEC [NV] = '{
    {1'b1, 32'hFFFFFFFF, 32'h01FFFFFF},  // R2 reserved bits dropped
    {1'b1, 32'h00000000, 32'h00000000},
    {1'b0, 32'hFFFFFFFF, 32'h00000000},  // R3 locked
    {1'b1, 32'hAA55A5A5, 32'h0055A5A5},  // R2
    {1'b0, 32'h12345678, 32'h0055A5A5},  // R3 locked
    {1'b1, 32'h00850943, 32'h00850943}   // lead 1, 5, 9, 2, 3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic unl, input logic [31:0] d);
    cfg_unlock = unl; cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_unlock = 1'b0;
  endtask

  task automatic pulse_sr;
    sr_exit = 1'b1; @(negedge clk); sr_exit = 1'b0;
  endtask

  task automatic pulse_rd;
    rd_issue = 1'b1; @(negedge clk); rd_issue = 1'b0;
  endtask

  task automatic count_low_cke(output int n);
    n = 0;
    while (!cke_flip_ok && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic count_low_pre(output int n);
    n = 0;
    while (!pre_ok && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n_rd, n_nr, n;
    logic prev;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; cfg_unlock = 1'b0;
    sr_exit = 1'b0; rd_issue = 1'b0; cke_flip_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rdata", cfg_rdata, 32'h01FFFFFF);
    check("R1 flags", {28'd0, rd_ok, nonrd_ok, pre_ok, cke_flip_ok}, 32'hF);
    check("R1 cke_out", {31'd0, cke_out}, 32'd0);
    check("R8 reset lead", {30'd0, odt_lead}, 32'd3);

    for (int i = 0; i < NV; i++) begin
      reg_write(VEC[i][64], VEC[i][63:32]);
      check("R2/R3 readback", cfg_rdata, VEC[i][31:0]);
      check("R8 lead", {30'd0, odt_lead}, {30'd0, VEC[i][24:23]});
    end

    // R4 / R5: both windows after one exit, xnr=5, xrd=9
    pulse_sr;
    check("R6 pre blocked by exit", {31'd0, pre_ok}, 32'd0);
    n_rd = 0; n_nr = 0;
    for (int k = 0; k < 40; k++) begin
      if (!rd_ok) n_rd++;
      if (!nonrd_ok) n_nr++;
      @(negedge clk);
    end
    check("R4 non-read window", n_nr, 6);
    check("R5 read window", n_rd, 10);

    // R6: two reads back to back, window measured from the second
    pulse_rd;
    pulse_rd;
    count_low_pre(n);
    check("R6 restart window", n, 3);
    pulse_rd;
    count_low_pre(n);
    check("R6 single read window", n, 3);

    // R7: flip, then requests while blocked are ignored
    prev = cke_out;
    cke_flip_req = 1'b1; @(negedge clk); cke_flip_req = 1'b0;
    check("R7 flip", {31'd0, cke_out}, {31'd0, ~prev});
    cke_flip_req = 1'b1; @(negedge clk); cke_flip_req = 1'b0;
    check("R7 ignored while blocked", {31'd0, cke_out}, {31'd0, ~prev});
    count_low_cke(n);
    check("R7 spacing remainder", n, 3);
    cke_flip_req = 1'b1; @(negedge clk); cke_flip_req = 1'b0;
    check("R7 second flip", {31'd0, cke_out}, {31'd0, prev});
    count_low_cke(n);
    check("R7 spacing", n, 4);

    // R9: rewrite xnr to 0 during countdown
    pulse_sr;
    n = 1;
    reg_write(1'b1, 32'h00800943);
    while (!nonrd_ok && n < 1000) begin n++; @(negedge clk); end
    check("R9 old value kept", n, 6);
    repeat (12) @(negedge clk);
    pulse_sr;
    n = 0;
    while (!nonrd_ok && n < 1000) begin n++; @(negedge clk); end
    check("R9 new value applied", n, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule